// File: doc/BRIEF.md
# Far-End Alarm Codeword Receiver

This block watches a serial alarm-and-control bit channel and recovers the 6-bit codes carried on it. The bits arrive one at a time; a bit is taken only on a cycle where the valid strobe is high. Every codeword is 16 bits long. It holds a run of eight ones, a zero, the six code bits and a closing zero. The block first finds codeword alignment from the data itself. Once it is aligned, it checks each later 16-bit window in full.

A code is not accepted the first time it is seen. It must arrive in several consecutive, correctly framed codewords (four by default). Only then is it latched into the status output, and a one-cycle update strobe is raised with it. The status keeps its value until a different code completes its own run. The bus decoding, the logic that extracts the channel from its carrier frame and the interrupt logic all sit outside this block.

Top module: `feac_receiver`

## Requirements
- R1: After synchronous reset, `codeOut` is 6'h3F and `codeStrobe` is 0.
- R2: Bits arrive in this order: eight ones, one zero, code bits 0 through 5, then one zero. Bit n of `codeOut` is the n-th code bit received.
- R3: `codeOut` changes only when the same code has been received in 4 consecutive, correctly framed codewords. Three repeats leave it unchanged.
- R4: `codeStrobe` is high for exactly one cycle. That cycle is the one right after the clock edge that samples the last bit of the accepting codeword. `codeOut` carries the new code in the same cycle.
- R5: Further repeats of an accepted code give no strobe and do not change `codeOut`.
- R6: A correctly framed codeword whose code differs from the previous codeword's code restarts the run count at one, for the new code.
- R7: A locked codeword whose closing zero is a one clears the run count to zero. Alignment is then searched for again.
- R8: Alignment is declared only on a zero that follows at least eight consecutive ones. Seven ones and a zero do not align, and more than eight ones before the zero still align.
- R9: Cycles with `bitValid` low are ignored, whatever value `bitIn` has.
- R10: A locked codeword with a zero anywhere in its eight-ones field counts as bad framing. It clears the run count, just as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Serial channel bit |
| codeOut | output | 6 | Last accepted code |
| codeStrobe | output | 1 | One-cycle pulse when `codeOut` is updated |

## Verification
The bench sends runs of three codewords that must not be accepted, then a fourth that must be. A design that counted off by one would update early or late. It also checks a code change in the middle of a run, and a wrong restart value there would move the update by one codeword. A broken closing zero and a broken marker field are each followed by a fresh run of four, which catches a design that keeps its count across bad framing. A noise prefix with seven ones and a zero catches early locking. Bits sent with idle gaps in between, while `bitIn` toggles, expose a design that samples without `bitValid`.

// File: rtl/feac_pkg.sv
package feac_pkg;
  typedef enum logic {HUNT, LOCK} feacState_e;

  typedef struct packed {
    logic shiftEn;
    logic frameDone;
  } feacCtrl_t;
endpackage

// File: rtl/feac_control.sv
module feac_control
  import feac_pkg::*;
#(
  parameter int MARK_W = 8,
  parameter int CODE_W = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bitValid,
  input  logic      bitIn,
  input  logic      frameOk,
  output feacCtrl_t ctrl
);
  localparam int WORD_W = MARK_W + CODE_W + 2;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int ONE_W  = $clog2(MARK_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] LOCK_POS  = BIT_W'(MARK_W + 1);
  localparam logic [ONE_W-1:0] ONES_FULL = ONE_W'(MARK_W);

  feacState_e       state;
  logic [BIT_W-1:0] bitCnt;
  logic [ONE_W-1:0] onesCnt;

  always_comb begin
    ctrl.shiftEn   = bitValid;
    ctrl.frameDone = bitValid && (state == LOCK) && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= HUNT;
      bitCnt  <= '0;
      onesCnt <= '0;
    end else if (bitValid) begin
      if (state == HUNT) begin
        if (bitIn) begin
          if (onesCnt != ONES_FULL) onesCnt <= onesCnt + 1'b1;
        end else begin
          if (onesCnt == ONES_FULL) begin
            state  <= LOCK;
            bitCnt <= LOCK_POS;
          end
          onesCnt <= '0;
        end
      end else begin
        if (bitCnt == LAST_BIT) begin
          bitCnt <= '0;
          if (!frameOk) begin
            state   <= HUNT;
            onesCnt <= '0;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R8
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == LOCK && $past(state) == HUNT) |-> ($past(bitValid) && !$past(bitIn)));

  // R8
  lock_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state == LOCK) |-> (bitCnt == LOCK_POS));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> ($stable(bitCnt) && $stable(onesCnt)));

  hunt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    onesCnt <= ONES_FULL);
endmodule

// File: rtl/feac_datapath.sv
module feac_datapath
  import feac_pkg::*;
#(
  parameter int MARK_W = 8,
  parameter int CODE_W = 6,
  parameter int REPEAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitIn,
  input  feacCtrl_t         ctrl,
  output logic              frameOk,
  output logic [CODE_W-1:0] codeOut,
  output logic              codeStrobe
);
  localparam int WORD_W = MARK_W + CODE_W + 2;
  localparam int CNT_W  = $clog2(REPEAT + 1);
  localparam logic [CNT_W-1:0] REP_MAX = CNT_W'(REPEAT);

  logic [WORD_W-1:0] shReg, win;
  logic [CODE_W-1:0] lastCode, newCode;
  logic [CNT_W-1:0]  matchCnt, nextCnt;
  logic              sameCode, fire;

  always_comb begin
    win      = {bitIn, shReg[WORD_W-1:1]};
    newCode  = win[MARK_W+CODE_W -: CODE_W];
    frameOk  = (&win[MARK_W-1:0]) & ~win[MARK_W] & ~win[WORD_W-1];
    sameCode = (matchCnt != '0) && (newCode == lastCode);
    if (!sameCode)               nextCnt = CNT_W'(1);
    else if (matchCnt == REP_MAX) nextCnt = matchCnt;
    else                          nextCnt = matchCnt + 1'b1;
    fire = ctrl.frameDone && frameOk && (nextCnt == REP_MAX)
           && !(sameCode && (matchCnt == REP_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg      <= '0;
      lastCode   <= '0;
      matchCnt   <= '0;
      codeOut    <= '1;
      codeStrobe <= 1'b0;
    end else begin
      codeStrobe <= fire;
      if (ctrl.shiftEn) shReg <= win;
      if (ctrl.frameDone) begin
        if (!frameOk) begin
          matchCnt <= '0;
        end else begin
          matchCnt <= nextCnt;
          lastCode <= newCode;
        end
      end
      if (fire) codeOut <= newCode;
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    codeStrobe |=> !codeStrobe);

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !codeStrobe |-> (codeOut == $past(codeOut)));

  // R3
  strobe_count_chk: assert property (@(posedge clk) disable iff (rst)
    codeStrobe |-> (matchCnt == REP_MAX));

  // R6
  match_bound_chk: assert property (@(posedge clk) disable iff (rst)
    matchCnt <= REP_MAX);
endmodule

// File: rtl/feac_receiver.sv
module feac_receiver
  import feac_pkg::*;
#(
  parameter int MARK_W = 8,
  parameter int CODE_W = 6,
  parameter int REPEAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              bitIn,
  output logic [CODE_W-1:0] codeOut,
  output logic              codeStrobe
);
  feacCtrl_t ctrl;
  logic      frameOk;

  feac_control #(.MARK_W(MARK_W), .CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .frameOk(frameOk), .ctrl(ctrl)
  );

  feac_datapath #(.MARK_W(MARK_W), .CODE_W(CODE_W), .REPEAT(REPEAT)) dp_i (
    .clk(clk), .rst(rst), .bitIn(bitIn), .ctrl(ctrl),
    .frameOk(frameOk), .codeOut(codeOut), .codeStrobe(codeStrobe)
  );

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $past(rst) |-> (codeOut == '1 && !codeStrobe));
endmodule

// File: tb/feac_receiver_tb.sv
module feac_receiver_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic [5:0] codeOut;
  logic       codeStrobe;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  feac_receiver dut_i (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .codeOut(codeOut), .codeStrobe(codeStrobe)
  );

  // behavioural reference model
  int q[$];
  bit hunting = 1'b1;
  int ones = 0, pos = 0, run = 0, prev = 0;
  int expCode = 63;
  bit expStb = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); hunting = 1; ones = 0; pos = 0; run = 0; prev = 0;
      expCode = 63; expStb = 0;
    end else begin
      expStb = 0;
      if (bitValid) begin
        q.push_back(int'(bitIn));
        if (q.size() > 16) void'(q.pop_front());
        if (hunting) begin
          if (bitIn) ones = (ones < 8) ? ones + 1 : 8;
          else begin
            if (ones == 8) begin hunting = 0; pos = 9; end
            ones = 0;
          end
        end else begin
          pos++;
          if (pos == 16) begin
            bit ok;
            int code;
            pos = 0;
            ok = (q[8] == 0) && (q[15] == 0);
            for (int k = 0; k < 8; k++) if (q[k] != 1) ok = 0;
            code = 0;
            for (int k = 0; k < 6; k++) code += q[9+k] << k;
            if (!ok) begin
              run = 0; hunting = 1; ones = 0;
            end else if (run > 0 && code == prev) begin
              if (run < 4) begin
                run++;
                if (run == 4) begin expCode = code; expStb = 1; end
              end
            end else begin
              prev = code; run = 1;
            end
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model code", int'(codeOut), expCode);
      chk("R4 model strobe", int'(codeStrobe), int'(expStb));
    end
  end

  task automatic sendBit(bit b, int gap);
    for (int g = 0; g < gap; g++) begin
      bitValid = 0; bitIn = ~bitIn; @(negedge clk);
    end
    bitValid = 1; bitIn = b; @(negedge clk);
    bitValid = 0;
  endtask

  task automatic sendWord(int code, bit badTrail = 0, int badMark = -1, int gap = 0);
    for (int i = 0; i < 16; i++) begin
      bit b;
      if (i < 8)        b = (i == badMark) ? 1'b0 : 1'b1;
      else if (i == 8)  b = 1'b0;
      else if (i < 15)  b = code[i-9];
      else              b = badTrail;
      sendBit(b, gap);
    end
  endtask

  task automatic sendRun(int code, int n);
    for (int i = 0; i < n; i++) sendWord(code);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset code", int'(codeOut), 63);
    chk("R1 reset strobe", int'(codeStrobe), 0);

    // R8: seven ones then zero must not align; long ones run still aligns
    for (int i = 0; i < 7; i++) sendBit(1, 0);
    sendBit(0, 0); sendBit(0, 0); sendBit(1, 0); sendBit(0, 0);
    for (int i = 0; i < 5; i++) sendBit(1, 0);
    sendRun(6'h2D, 3);
    chk("R3 three repeats no update", int'(codeOut), 63);
    sendWord(6'h2D);
    chk("R4 strobe on accept", int'(codeStrobe), 1);
    chk("R2 R8 accepted code", int'(codeOut), 6'h2D);
    @(negedge clk);
    chk("R4 strobe one cycle", int'(codeStrobe), 0);

    // R5: further repeats
    sendWord(6'h2D);
    chk("R5 no strobe on repeat", int'(codeStrobe), 0);
    sendWord(6'h2D);
    chk("R5 code kept", int'(codeOut), 6'h2D);

    // R6: change of code restarts the run at one
    sendRun(6'h12, 3);
    sendRun(6'h07, 3);
    chk("R6 no early update", int'(codeOut), 6'h2D);
    sendWord(6'h07);
    chk("R6 update after new run", int'(codeOut), 6'h07);
    chk("R6 strobe", int'(codeStrobe), 1);

    // R7: bad closing zero clears the run
    sendRun(6'h3A, 3);
    sendWord(6'h3A, 1);
    chk("R7 bad trail no update", int'(codeOut), 6'h07);
    sendRun(6'h3A, 3);
    chk("R7 count cleared", int'(codeOut), 6'h07);
    sendWord(6'h3A);
    chk("R7 update after fresh run", int'(codeOut), 6'h3A);

    // R10: zero inside marker while locked
    sendRun(6'h01, 3);
    sendWord(6'h01, 0, 3);
    chk("R10 bad marker no update", int'(codeOut), 6'h3A);
    sendRun(6'h01, 3);
    chk("R10 count cleared", int'(codeOut), 6'h3A);
    sendWord(6'h01);
    chk("R10 update after fresh run", int'(codeOut), 6'h01);

    // R9: idle cycles with toggling data are ignored
    for (int i = 0; i < 3; i++) sendWord(6'h15, 0, -1, 2);
    chk("R9 three gapped words no update", int'(codeOut), 6'h01);
    sendWord(6'h15, 0, -1, 3);
    chk("R9 gapped accept", int'(codeOut), 6'h15);
    chk("R9 gapped strobe", int'(codeStrobe), 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule